// File: doc/BRIEF.md
# Quadrature Position Tracker

This block turns the two phase-shifted square waves of an incremental encoder into a signed-free 16-bit position count. Each input, channel A, channel B and the once-per-turn index, is first brought into the system clock domain through a two-flop synchronizer. It then passes a digital glitch filter that accepts a new level only once that level has held for a programmable number of clocks.

The decoder compares the previous and the current filtered two-bit state {A,B}. Every edge of either channel moves the count by one, which gives four counts per encoder cycle. The order of the edges selects the direction. A sample in which both channels change together is physically impossible for a clean encoder. Such a sample leaves the count alone and raises a sticky error flag.

While the filtered index is high and both channels are high, the count is forced to a reference value. The reset therefore always lands on the same quadrature state. Position, direction and error are plain status outputs; the block has no streaming interface, so no valid/ready handshake applies.

Top module: `quad_pos_tracker`

## Requirements
- R1: After reset, `pos` is 0, `dir` is 0 and `err` is 0; reset also returns `err` to 0 after it was set.
- R2: With the state written as {A,B}, each filtered transition 00→01, 01→11, 11→10 or 10→00 increments `pos` by one and sets `dir` to 1.
- R3: Each filtered transition 01→00, 11→01, 10→11 or 00→10 decrements `pos` by one and sets `dir` to 0.
- R4: A filtered transition in which A and B both change leaves `pos` and `dir` unchanged and sets `err`, which stays 1 through later valid steps until reset.
- R5: While the filtered index, A and B are all 1, `pos` is loaded with `ref_pos`; an index pulse in any other {A,B} state has no effect on `pos`.
- R6: Each input takes a new level only after the synchronized input has differed from the current level for N consecutive clocks, N = `filt_len` (0 acts as 1); a pulse lasting N-1 clocks is ignored.
- R7: An input change applied between clock edges shows on `pos`, `dir` and `err` at the (N+3)th rising edge after it, and not earlier.
- R8: The count wraps: incrementing 16'hFFFF gives 16'h0000 and decrementing 16'h0000 gives 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| filt_len | input | 4 | Filter length N in clocks (0 treated as 1) |
| ref_pos | input | 16 | Value loaded into the count at the index state |
| enc_a | input | 1 | Encoder channel A, asynchronous |
| enc_b | input | 1 | Encoder channel B, asynchronous |
| enc_idx | input | 1 | Encoder index, asynchronous |
| pos | output | 16 | Position count |
| dir | output | 1 | Direction of the last counted step, 1 for up |
| err | output | 1 | Sticky flag for a simultaneous A/B change |

## Verification
Each result is due at the (N+3)th rising edge after its stimulus: two synchronizer flops, N filter clocks, and the counter register. The driver pushes every expected change of `pos` into a queue as it applies a step. The monitor pops the queue in order whenever the output moves, so an extra, missing or wrong change is caught whatever its timing. Direct checks of `dir`, `err` and the unchanged cases are made only after N+4 clocks. The latency checks sample at exactly N+2 and N+3 edges, for N of 3 and for N of 0 treated as 1.

// File: rtl/qpt_pkg.sv
package qpt_pkg;

  typedef enum int {
    CH_A   = 0,
    CH_B   = 1,
    CH_IDX = 2
  } qpt_chan_e;

  localparam int NUM_CH = 3;

  // Rank of a {A,B} state along the forward Gray walk 00,01,11,10.
  function automatic logic [1:0] gray_rank(input logic [1:0] s);
    return {s[1], s[1] ^ s[0]};
  endfunction

endpackage

// File: rtl/qpt_glitch_filter.sv
module qpt_glitch_filter #(
  parameter int FILT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FILT_W-1:0] len,
  input  logic              din,
  output logic              dout
);

  localparam logic [FILT_W-1:0] ONE = FILT_W'(1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_W-1:0]      run_q;
  logic [FILT_W-1:0]      need;
  logic                   s_in;
  logic                   reach;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
  end

  assign s_in  = sync_q[SYNC_STAGES-1];
  assign need  = (len == '0) ? ONE : len;
  assign reach = ({1'b0, run_q} + {{FILT_W{1'b0}}, 1'b1}) >= {1'b0, need};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
      dout  <= 1'b0;
    end else if (s_in == dout) begin
      run_q <= '0;
    end else if (reach) begin
      run_q <= '0;
      dout  <= s_in;
    end else begin
      run_q <= run_q + ONE;
    end
  end

endmodule

// File: rtl/qpt_step_decode.sv
module qpt_step_decode
  import qpt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ab,
  output logic       step_up,
  output logic       step_dn,
  output logic       step_bad
);

  logic [1:0] prev_q;
  logic [1:0] delta;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 2'b00;
    else        prev_q <= ab;
  end

  assign delta    = gray_rank(ab) - gray_rank(prev_q);
  assign step_up  = (delta == 2'd1);
  assign step_dn  = (delta == 2'd3);
  assign step_bad = (delta == 2'd2);

endmodule

// File: rtl/qpt_pos_counter.sv
module qpt_pos_counter #(
  parameter int POS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [POS_W-1:0] load_val,
  input  logic             step_up,
  input  logic             step_dn,
  input  logic             step_bad,
  output logic [POS_W-1:0] pos,
  output logic             dir,
  output logic             err
);

  localparam logic [POS_W-1:0] ONE = POS_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= '0;
      dir <= 1'b0;
      err <= 1'b0;
    end else begin
      if (step_bad) err <= 1'b1;
      if (load) begin
        pos <= load_val;
      end else if (step_up) begin
        pos <= pos + ONE;
        dir <= 1'b1;
      end else if (step_dn) begin
        pos <= pos - ONE;
        dir <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/quad_pos_tracker.sv
module quad_pos_tracker
  import qpt_pkg::*;
#(
  parameter int POS_W       = 16,
  parameter int FILT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FILT_W-1:0] filt_len,
  input  logic [POS_W-1:0]  ref_pos,
  input  logic              enc_a,
  input  logic              enc_b,
  input  logic              enc_idx,
  output logic [POS_W-1:0]  pos,
  output logic              dir,
  output logic              err
);

  logic [NUM_CH-1:0] raw_in;
  logic [NUM_CH-1:0] flt;
  logic              f_a;
  logic              f_b;
  logic              f_idx;
  logic              up;
  logic              dn;
  logic              bad;
  logic              idx_hit;

  assign raw_in[CH_A]   = enc_a;
  assign raw_in[CH_B]   = enc_b;
  assign raw_in[CH_IDX] = enc_idx;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_in
    qpt_glitch_filter #(
      .FILT_W      (FILT_W),
      .SYNC_STAGES (SYNC_STAGES)
    ) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .len   (filt_len),
      .din   (raw_in[ch]),
      .dout  (flt[ch])
    );
  end

  assign f_a     = flt[CH_A];
  assign f_b     = flt[CH_B];
  assign f_idx   = flt[CH_IDX];
  assign idx_hit = f_idx & f_a & f_b;

  qpt_step_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .ab       ({f_a, f_b}),
    .step_up  (up),
    .step_dn  (dn),
    .step_bad (bad)
  );

  qpt_pos_counter #(.POS_W(POS_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (idx_hit),
    .load_val (ref_pos),
    .step_up  (up),
    .step_dn  (dn),
    .step_bad (bad),
    .pos      (pos),
    .dir      (dir),
    .err      (err)
  );

endmodule

// File: rtl/qpt_checker.sv
module qpt_checker #(
  parameter int POS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             f_a,
  input logic             f_b,
  input logic             f_idx,
  input logic [POS_W-1:0] ref_pos,
  input logic [POS_W-1:0] pos,
  input logic             dir,
  input logic             err
);

  localparam logic [POS_W-1:0] ONE = POS_W'(1);

  logic [1:0] ab_q;
  logic [1:0] ab;
  logic       ld;
  logic       fwd;
  logic       rev;
  logic       both;

  assign ab = {f_a, f_b};
  assign ld = f_idx && f_a && f_b;

  always_ff @(posedge clk) begin
    if (!rst_n) ab_q <= 2'b00;
    else        ab_q <= ab;
  end

  always_comb begin
    fwd = 1'b0;
    rev = 1'b0;
    case ({ab_q, ab})
      4'b0001, 4'b0111, 4'b1110, 4'b1000: fwd = 1'b1;
      4'b0100, 4'b1101, 4'b1011, 4'b0010: rev = 1'b1;
      default: ;
    endcase
  end
  assign both = (ab_q[1] != ab[1]) && (ab_q[0] != ab[0]);

  a_r1_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> (pos == $past(pos) || pos == $past(pos) + ONE || pos == $past(pos) - ONE));

  a_r2_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd && !ld) |=> (dir && pos == $past(pos) + ONE));

  a_r3_down_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rev && !ld) |=> (!dir && pos == $past(pos) - ONE));

  a_r4_double_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (both && !ld) |=> (err && $stable(pos) && $stable(dir)));

  a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  a_r5_index_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (pos == $past(ref_pos)));

endmodule

bind quad_pos_tracker qpt_checker #(.POS_W(POS_W)) u_qpt_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .f_a     (f_a),
  .f_b     (f_b),
  .f_idx   (f_idx),
  .ref_pos (ref_pos),
  .pos     (pos),
  .dir     (dir),
  .err     (err)
);

// File: tb/quad_pos_tracker_tb.sv
module quad_pos_tracker_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  filt_len = 4'd2;
  logic [15:0] ref_pos = 16'h0;
  logic        enc_a = 1'b0;
  logic        enc_b = 1'b0;
  logic        enc_idx = 1'b0;
  logic [15:0] pos;
  logic        dir;
  logic        err;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_pos_tracker u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .filt_len (filt_len),
    .ref_pos  (ref_pos),
    .enc_a    (enc_a),
    .enc_b    (enc_b),
    .enc_idx  (enc_idx),
    .pos      (pos),
    .dir      (dir),
    .err      (err)
  );

  int errors = 0;
  int checks = 0;

  // bench model
  logic [15:0] m_pos = 16'h0;
  logic        m_dir = 1'b0;
  logic        m_err = 1'b0;
  logic [1:0]  m_ab  = 2'b00;
  int          n_eff = 2;

  // scoreboard
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] seen_pos = 16'h0;
  bit          mon_en = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_pos(input logic [15:0] v, input string tag);
    if (v != m_pos) begin
      exp_q.push_back(v);
      tag_q.push_back(tag);
    end
    m_pos = v;
  endtask

  task automatic set_len(input logic [3:0] l);
    filt_len = l;
    n_eff = (l == 4'd0) ? 1 : int'(l);
  endtask

  // drive a new {A,B} state and update the model; no wait
  task automatic drive_ab(input logic [1:0] nab, input string tag);
    logic [3:0] tr;
    tr = {m_ab, nab};
    enc_a = nab[1];
    enc_b = nab[0];
    case (tr)
      4'b0001, 4'b0111, 4'b1110, 4'b1000: begin
        push_pos(m_pos + 16'd1, tag); m_dir = 1'b1;
      end
      4'b0100, 4'b1101, 4'b1011, 4'b0010: begin
        push_pos(m_pos - 16'd1, tag); m_dir = 1'b0;
      end
      4'b0011, 4'b1100, 4'b0110, 4'b1001: m_err = 1'b1;
      default: ;
    endcase
    m_ab = nab;
  endtask

  task automatic move(input logic [1:0] nab, input string tag);
    drive_ab(nab, tag);
    wait_n(n_eff + 4);
    chk(pos == m_pos, tag, pos, m_pos);
    chk(dir == m_dir, tag, {15'd0, dir}, {15'd0, m_dir});
  endtask

  // monitor: every change of pos must match the next queued value
  always @(negedge clk) begin
    if (mon_en && rst_n && pos != seen_pos) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL unexpected pos change: actual=%h expected=%h", pos, seen_pos);
      end else begin
        automatic logic [15:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(pos == e, t, pos, e);
      end
      seen_pos = pos;
    end
  end

  task automatic do_reset();
    mon_en = 1'b0;
    rst_n = 1'b0;
    enc_a = 1'b0; enc_b = 1'b0; enc_idx = 1'b0;
    wait_n(n_eff + 6);
    chk(pos == 16'h0, "R1 reset pos", pos, 16'h0);
    chk(dir == 1'b0, "R1 reset dir", {15'd0, dir}, 16'h0);
    chk(err == 1'b0, "R1 reset err", {15'd0, err}, 16'h0);
    rst_n = 1'b1;
    m_pos = 16'h0; m_dir = 1'b0; m_err = 1'b0; m_ab = 2'b00;
    seen_pos = 16'h0;
    mon_en = 1'b1;
    wait_n(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    set_len(4'd2);
    do_reset();

    // R2: forward walk
    move(2'b01, "R2 up 00-01");
    move(2'b11, "R2 up 01-11");
    move(2'b10, "R2 up 11-10");
    move(2'b00, "R2 up 10-00");
    chk(pos == 16'd4, "R2 four counts per cycle", pos, 16'd4);

    // R3: reverse walk
    move(2'b10, "R3 down 00-10");
    move(2'b11, "R3 down 10-11");
    move(2'b01, "R3 down 11-01");
    move(2'b00, "R3 down 01-00");

    // R8: wrap both ways
    move(2'b10, "R8 wrap 0000-FFFF");
    chk(pos == 16'hFFFF, "R8 down wrap", pos, 16'hFFFF);
    move(2'b00, "R8 wrap FFFF-0000");
    chk(pos == 16'h0000, "R8 up wrap", pos, 16'h0000);

    // R7: latency with N=3
    set_len(4'd3);
    wait_n(2);
    drive_ab(2'b01, "R7 step N=3");
    wait_n(n_eff + 2);
    chk(pos == 16'h0000, "R7 not before edge N+3", pos, 16'h0000);
    wait_n(1);
    chk(pos == 16'h0001, "R7 at edge N+3", pos, 16'h0001);
    wait_n(2);

    // R7/R6: filt_len 0 acts as 1
    set_len(4'd0);
    wait_n(2);
    drive_ab(2'b11, "R6 len0 step");
    wait_n(3);
    chk(pos == 16'h0001, "R6 len0 not before edge 4", pos, 16'h0001);
    wait_n(1);
    chk(pos == 16'h0002, "R6 len0 at edge 4", pos, 16'h0002);
    wait_n(2);

    // R6: glitch rejection with N=4
    set_len(4'd4);
    wait_n(2);
    enc_b = 1'b0;
    wait_n(3);
    enc_b = 1'b1;
    wait_n(n_eff + 4);
    chk(pos == m_pos, "R6 pulse of N-1 ignored", pos, m_pos);
    enc_a = 1'b0;
    wait_n(1);
    enc_a = 1'b1;
    wait_n(n_eff + 4);
    chk(pos == m_pos, "R6 one-clock pulse ignored", pos, m_pos);
    // pulse of exactly N is accepted: 11->10 up, then 10->11 down
    drive_ab(2'b10, "R6 pulse N accepted up");
    wait_n(4);
    drive_ab(2'b11, "R6 pulse N accepted down");
    wait_n(n_eff + 8);
    chk(pos == m_pos, "R6 pulse of N net", pos, m_pos);

    // R5: index at {A,B}=11 loads the reference
    set_len(4'd2);
    ref_pos = 16'h1234;
    wait_n(2);
    enc_idx = 1'b1;
    push_pos(16'h1234, "R5 index load");
    wait_n(n_eff + 4);
    chk(pos == 16'h1234, "R5 index at 11 loads", pos, 16'h1234);
    enc_idx = 1'b0;
    wait_n(n_eff + 4);
    move(2'b10, "R5 count after index");
    chk(pos == 16'h1235, "R5 step from reference", pos, 16'h1235);

    // R5: index in state 10 ignored
    enc_idx = 1'b1;
    wait_n(n_eff + 4);
    chk(pos == 16'h1235, "R5 index at 10 ignored", pos, 16'h1235);
    enc_idx = 1'b0;
    wait_n(n_eff + 4);

    // R8 again via reference near the top
    move(2'b11, "R8 back to 11");
    ref_pos = 16'hFFFE;
    enc_idx = 1'b1;
    push_pos(16'hFFFE, "R8 load FFFE");
    wait_n(n_eff + 4);
    enc_idx = 1'b0;
    wait_n(n_eff + 4);
    move(2'b10, "R8 FFFE-FFFF");
    move(2'b00, "R8 FFFF-0000");
    chk(pos == 16'h0000, "R8 wrap from reference", pos, 16'h0000);

    // R4: both channels change together
    chk(err == 1'b0, "R4 err clear before", {15'd0, err}, 16'h0);
    move(2'b11, "R4 double change no count");
    chk(err == 1'b1, "R4 err set", {15'd0, err}, 16'h1);
    chk(pos == 16'h0000, "R4 pos held", pos, 16'h0000);
    move(2'b10, "R4 valid step after error");
    chk(err == 1'b1, "R4 err sticky", {15'd0, err}, 16'h1);

    // R1: reset clears the sticky flag
    set_len(4'd2);
    do_reset();
    chk(err == 1'b0, "R1 err cleared by reset", {15'd0, err}, 16'h0);

    wait_n(4);
    chk(exp_q.size() == 0, "all expected pos changes seen",
        16'(exp_q.size()), 16'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule